// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two 16-bit address pointers and a one-bit bank selector for an 8051-style core. The selector picks the pointer that every core-side pointer operation uses. The core can read the active pointer, load it as a whole word, or step it by one. A block-move routine keeps the source address in one pointer and the destination address in the other. It switches between them with one increment of the selector, so it never has to save and restore addresses.

Software reaches the five byte registers through a register port with an 8-bit address, a write strobe, write data and read data. Reads return data in the same cycle. A hit flag tells an outer register multiplexer when this block owns the addressed location. Any other address reads as zero and leaves the hit flag low.

Top module: `ptr_bank_unit`

## Requirements
- R1: Register addresses are 82h for pointer 0 low byte, 83h for pointer 0 high byte, 84h for pointer 1 low byte, 85h for pointer 1 high byte and 86h for the selector. Each pointer byte reads back the value last written to it.
- R2: After reset both pointers are 0000h and the selector reads 00h, so pointer 0 is active.
- R3: Only bit 0 of the selector at 86h is stored (0 = pointer 0 active, 1 = pointer 1 active). Bits 7..1 ignore writes and always read 0. `sel_state` shows the stored bit.
- R4: `core_ptr` shows the pointer named by the selector. A `core_load` writes `core_load_val` into that pointer one cycle later and leaves the other pointer unchanged.
- R5: A pulse on `core_sel_inc` inverts the selector bit in one cycle, which switches the active pointer.
- R6: A `core_inc` adds one to the active pointer as a 16-bit value. The low byte carries into the high byte, FFFFh wraps to 0000h, and the inactive pointer keeps its value.
- R7: When `core_load` and `core_inc` are both high, the load wins.
- R8: An SFR write to either byte of a pointer in the same cycle as a core load or increment of that pointer wins. The written byte takes the SFR data, the other byte keeps its old value, and the core update is dropped. An SFR write to 86h likewise wins over `core_sel_inc`.
- R9: A read at any address outside 82h..86h returns 00h with `sfr_hit` low. A write to such an address changes no register. Reads inside the range raise `sfr_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, combinational |
| sfr_hit | output | 1 | Address belongs to this block |
| core_ptr | output | 16 | Active pointer value |
| core_load | input | 1 | Load the active pointer with core_load_val |
| core_load_val | input | 16 | Value for core_load |
| core_inc | input | 1 | Increment the active pointer |
| core_sel_inc | input | 1 | Increment (toggle) the selector |
| sel_state | output | 1 | Current selector bit |

## Verification
The bench drives the carry paths FFFFh and 00FFh. A design with a broken carry would show 0000h or 01FFh wrongly, or leave the high byte stuck. It reads the inactive pointer back over the register port after each core operation. That exposes a design that updates both pointers or ignores the selector. It creates collisions in one cycle: SFR write against increment, load against increment, and selector write against selector toggle. A wrong priority there leaves the core's value in place of the written byte. It also writes all ones to the selector and accesses unmapped addresses. A design that stores the upper bits, or decodes too widely, reads back nonzero or raises the hit flag.

// File: rtl/ptr_bank_pkg.sv
// Shared constants for the dual pointer unit.
// Assumes the five registers sit at consecutive addresses starting at PB_BASE.
package ptr_bank_pkg;
    localparam int PB_BYTE_W  = 8;
    localparam int PB_NUM_REG = 5;
    localparam logic [7:0] PB_BASE = 8'h82;
endpackage

// File: rtl/ptr_sfr_decode.sv
// Address decoder for the register port.
// Maps the five consecutive addresses to a pointer index, a byte half and a selector hit.
// Assumes BASE + NUM_REG - 1 does not wrap past the top of the address space.
module ptr_sfr_decode #(
    parameter int ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'h82,
    parameter int NUM_REG = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              sel_hit,
    output logic              ptr_idx,
    output logic              hi_half
);
    localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(NUM_REG - 1);

    logic [ADDR_W-1:0] off;

    // Offset from the base; addresses below the base wrap to large values and miss.
    always_comb begin
        off     = addr - BASE;
        hit     = (off <= LAST_OFF);
        sel_hit = (off == LAST_OFF);
        ptr_idx = off[1];
        hi_half = off[0];
    end
endmodule

// File: rtl/ptr_word_reg.sv
// One 16-bit pointer register built from two bytes.
// Byte writes from the register port win over core load and increment in the same cycle.
// Core operations act only when this pointer is the active one.
module ptr_word_reg #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                active,
    input  logic                core_load,
    input  logic [2*BYTE_W-1:0] core_val,
    input  logic                core_inc,
    output logic [2*BYTE_W-1:0] value
);
    localparam int WORD_W = 2 * BYTE_W;

    logic              sfr_touch;
    logic              core_go;
    logic [WORD_W-1:0] core_next;

    // Choose the core result: load has priority over increment.
    always_comb begin
        sfr_touch = wr_lo | wr_hi;
        core_go   = active & (core_load | core_inc) & ~sfr_touch;
        core_next = core_load ? core_val : value + WORD_W'(1);
    end

    // Pointer storage with reset, byte writes first, then core updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (sfr_touch) begin
            if (wr_lo) value[BYTE_W-1:0]      <= wdata;
            if (wr_hi) value[WORD_W-1:BYTE_W] <= wdata;
        end else if (core_go) begin
            value <= core_next;
        end
    end

    // R8: a written low byte takes the port data regardless of the core
    a_r8_lo_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> value[BYTE_W-1:0] == $past(wdata));

    // R8: the unwritten byte keeps its value during a byte write
    a_r8_other_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> value[WORD_W-1:BYTE_W] == $past(value[WORD_W-1:BYTE_W]));

    // R6: a lone increment on the active pointer adds one with wrap
    a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && core_inc && !core_load && !wr_lo && !wr_hi)
        |=> value == $past(value) + WORD_W'(1));

    // R4: an inactive pointer without byte writes holds its value
    a_r4_inactive_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_lo && !wr_hi) |=> $stable(value));
endmodule

// File: rtl/ptr_sel_reg.sv
// One-bit bank selector. A port write stores bit 0; a core increment inverts it.
// The port write wins when both occur together.
module ptr_sel_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    input  logic toggle,
    output logic sel
);
    // Selector storage: reset to bank 0, port write first, then toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= 1'b0;
        else if (wr)     sel <= wbit;
        else if (toggle) sel <= ~sel;
    end

    // R5: a toggle without a write inverts the selector
    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !wr) |=> sel != $past(sel));

    // R8: a port write sets the bit even when a toggle arrives together
    a_r8_sel_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> sel == $past(wbit));
endmodule

// File: rtl/ptr_bank_unit.sv
// Top level of the dual pointer unit.
// Holds two pointers and a selector. Serves the register port with same-cycle reads
// and the core port with operations on the selected pointer.
// Assumes at most one register access per cycle; the core pulses are single-cycle requests.
module ptr_bank_unit #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = ptr_bank_pkg::PB_BASE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   sfr_addr,
    input  logic                sfr_wr,
    input  logic [7:0]          sfr_wdata,
    output logic [7:0]          sfr_rdata,
    output logic                sfr_hit,
    output logic [15:0]         core_ptr,
    input  logic                core_load,
    input  logic [15:0]         core_load_val,
    input  logic                core_inc,
    input  logic                core_sel_inc,
    output logic                sel_state
);
    import ptr_bank_pkg::*;

    localparam int BW     = PB_BYTE_W;
    localparam int WW     = 2 * BW;
    localparam int NUM_PT = 2;

    logic                      hit;
    logic                      sel_hit;
    logic                      ptr_idx;
    logic                      hi_half;
    logic                      sel;
    logic [NUM_PT-1:0][WW-1:0] ptrs;

    ptr_sfr_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .NUM_REG(PB_NUM_REG)
    ) u_dec (
        .addr   (sfr_addr),
        .hit    (hit),
        .sel_hit(sel_hit),
        .ptr_idx(ptr_idx),
        .hi_half(hi_half)
    );

    ptr_sel_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sfr_wr & sel_hit),
        .wbit  (sfr_wdata[0]),
        .toggle(core_sel_inc),
        .sel   (sel)
    );

    for (genvar i = 0; i < NUM_PT; i++) begin : g_ptr
        logic ptr_sel_i;
        logic wr_here;
        assign ptr_sel_i = (i != 0);
        assign wr_here   = sfr_wr & hit & ~sel_hit & (ptr_idx == ptr_sel_i);

        ptr_word_reg #(.BYTE_W(BW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_here & ~hi_half),
            .wr_hi    (wr_here & hi_half),
            .wdata    (sfr_wdata),
            .active   (sel == ptr_sel_i),
            .core_load(core_load),
            .core_val (core_load_val),
            .core_inc (core_inc),
            .value    (ptrs[i])
        );
    end

    // Core view: the selected pointer and the selector bit.
    always_comb begin
        core_ptr  = ptrs[sel];
        sel_state = sel;
    end

    // Register read mux: zero and no hit outside the mapped range.
    always_comb begin
        sfr_hit   = hit;
        sfr_rdata = '0;
        if (hit) begin
            if (sel_hit)      sfr_rdata = {{(BW-1){1'b0}}, sel};
            else if (hi_half) sfr_rdata = ptrs[ptr_idx][WW-1:BW];
            else              sfr_rdata = ptrs[ptr_idx][BW-1:0];
        end
    end

    // R9: a miss always reads as zero
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_hit |-> sfr_rdata == 8'h00);

    // R3: the selector readback never carries upper bits
    a_r3_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_hit && sfr_addr == BASE + ADDR_W'(4)) |-> sfr_rdata[7:1] == 7'd0);

    // R4: the core view follows the selector
    a_r4_core_view: assert property (@(posedge clk) disable iff (!rst_n)
        core_ptr == (sel_state ? ptrs[1] : ptrs[0]));
endmodule

// File: tb/tb_ptr_bank_unit.sv
// Directed bench for ptr_bank_unit: one task per scenario, each checking its own results.
module tb_ptr_bank_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        sfr_hit;
    logic [15:0] core_ptr;
    logic        core_load = 1'b0;
    logic [15:0] core_load_val = 16'h0000;
    logic        core_inc = 1'b0;
    logic        core_sel_inc = 1'b0;
    logic        sel_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptr_bank_unit dut (
        .clk(clk), .rst_n(rst_n),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
        .core_ptr(core_ptr), .core_load(core_load), .core_load_val(core_load_val),
        .core_inc(core_inc), .core_sel_inc(core_sel_inc), .sel_state(sel_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Single-cycle register write; returns at a falling edge after the update.
    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wr = 1'b1; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        sfr_addr = a;
        #1;
        chk(req, {24'd0, sfr_rdata}, {24'd0, exp});
        chk(req, {31'd0, sfr_hit}, 32'd1);
    endtask

    // Single-cycle core request pulse.
    task automatic core_op(input logic ld, input logic [15:0] v, input logic inc, input logic tog);
        @(negedge clk);
        core_load = ld; core_load_val = v; core_inc = inc; core_sel_inc = tog;
        @(negedge clk);
        core_load = 1'b0; core_inc = 1'b0; core_sel_inc = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2 core_ptr", {16'd0, core_ptr}, 32'h0);
        chk("R2 sel_state", {31'd0, sel_state}, 32'h0);
        rd_chk("R2 p0lo", 8'h82, 8'h00);
        rd_chk("R2 p0hi", 8'h83, 8'h00);
        rd_chk("R2 p1lo", 8'h84, 8'h00);
        rd_chk("R2 p1hi", 8'h85, 8'h00);
        rd_chk("R2 sel", 8'h86, 8'h00);
    endtask

    task automatic t_map;
        wr_reg(8'h82, 8'h12);
        wr_reg(8'h83, 8'h34);
        wr_reg(8'h84, 8'h56);
        wr_reg(8'h85, 8'h78);
        rd_chk("R1 p0lo", 8'h82, 8'h12);
        rd_chk("R1 p0hi", 8'h83, 8'h34);
        rd_chk("R1 p1lo", 8'h84, 8'h56);
        rd_chk("R1 p1hi", 8'h85, 8'h78);
        chk("R4 core view p0", {16'd0, core_ptr}, 32'h3412);
    endtask

    task automatic t_sel_write;
        wr_reg(8'h86, 8'hFF);
        rd_chk("R3 sel upper bits", 8'h86, 8'h01);
        chk("R3 sel_state", {31'd0, sel_state}, 32'h1);
        chk("R4 core view p1", {16'd0, core_ptr}, 32'h7856);
        wr_reg(8'h86, 8'hFE);
        rd_chk("R3 sel bit0 clear", 8'h86, 8'h00);
        wr_reg(8'h86, 8'h01);
    endtask

    task automatic t_load;
        core_op(1'b1, 16'hABCD, 1'b0, 1'b0);
        chk("R4 load active", {16'd0, core_ptr}, 32'hABCD);
        rd_chk("R4 inactive lo kept", 8'h82, 8'h12);
        rd_chk("R4 inactive hi kept", 8'h83, 8'h34);
    endtask

    task automatic t_toggle;
        core_op(1'b0, 16'h0, 1'b0, 1'b1);
        chk("R5 toggle to 0", {31'd0, sel_state}, 32'h0);
        chk("R5 view p0", {16'd0, core_ptr}, 32'h3412);
        core_op(1'b0, 16'h0, 1'b0, 1'b1);
        chk("R5 toggle to 1", {31'd0, sel_state}, 32'h1);
        chk("R5 view p1", {16'd0, core_ptr}, 32'hABCD);
        core_op(1'b0, 16'h0, 1'b0, 1'b1);
    endtask

    task automatic t_inc;
        wr_reg(8'h82, 8'hFF);
        wr_reg(8'h83, 8'hFF);
        core_op(1'b0, 16'h0, 1'b1, 1'b0);
        chk("R6 wrap", {16'd0, core_ptr}, 32'h0000);
        rd_chk("R6 inactive lo", 8'h84, 8'hCD);
        rd_chk("R6 inactive hi", 8'h85, 8'hAB);
        wr_reg(8'h82, 8'hFF);
        wr_reg(8'h83, 8'h00);
        core_op(1'b0, 16'h0, 1'b1, 1'b0);
        chk("R6 carry", {16'd0, core_ptr}, 32'h0100);
        core_op(1'b0, 16'h0, 1'b1, 1'b0);
        chk("R6 plain step", {16'd0, core_ptr}, 32'h0101);
    endtask

    task automatic t_load_vs_inc;
        core_op(1'b1, 16'h5000, 1'b1, 1'b0);
        chk("R7 load wins", {16'd0, core_ptr}, 32'h5000);
    endtask

    task automatic t_collide;
        @(negedge clk);
        sfr_addr = 8'h82; sfr_wr = 1'b1; sfr_wdata = 8'h55; core_inc = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; core_inc = 1'b0;
        chk("R8 sfr beats inc", {16'd0, core_ptr}, 32'h5055);
        @(negedge clk);
        sfr_addr = 8'h83; sfr_wr = 1'b1; sfr_wdata = 8'h22;
        core_load = 1'b1; core_load_val = 16'hEEEE;
        @(negedge clk);
        sfr_wr = 1'b0; core_load = 1'b0;
        chk("R8 sfr beats load", {16'd0, core_ptr}, 32'h2255);
        @(negedge clk);
        sfr_addr = 8'h86; sfr_wr = 1'b1; sfr_wdata = 8'h00; core_sel_inc = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; core_sel_inc = 1'b0;
        chk("R8 sel write beats toggle", {31'd0, sel_state}, 32'h0);
    endtask

    task automatic t_miss;
        sfr_addr = 8'h81;
        #1;
        chk("R9 miss data low", {24'd0, sfr_rdata}, 32'h0);
        chk("R9 miss hit low", {31'd0, sfr_hit}, 32'h0);
        sfr_addr = 8'h87;
        #1;
        chk("R9 miss above", {23'd0, sfr_hit, sfr_rdata}, 32'h0);
        wr_reg(8'h81, 8'hA5);
        wr_reg(8'h87, 8'h5A);
        rd_chk("R9 p0lo untouched", 8'h82, 8'h55);
        rd_chk("R9 p0hi untouched", 8'h83, 8'h22);
        rd_chk("R9 p1lo untouched", 8'h84, 8'hCD);
        rd_chk("R9 p1hi untouched", 8'h85, 8'hAB);
        rd_chk("R9 sel untouched", 8'h86, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_sel_write();
        t_load();
        t_toggle();
        t_inc();
        t_load_vs_inc();
        t_collide();
        t_miss();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule